// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised storage register (eight bits by default) that can hold its contents, shift toward its high end, shift toward its low end, or capture a whole word in parallel. The parallel port is shared between input and output. It is presented as three signals: a captured input word, a driven output word and one drive-enable. A pad ring or on-chip tri-state resolver combines them. A two-bit mode select picks the operation for each rising clock edge. A synchronous active-low clear empties the register and overrides every mode.

While a capture is selected, the port drive is switched off so that another agent can put a word on the shared pins. In every other mode, the stored word is driven when both active-low enables are low. Two serial taps always show the lowest and highest stored bits, whatever the enables are doing. This lets several instances be chained as stacks or push-down stores.

Top module: `bidir_shift_reg`

## Requirements
- R1: When `clr_n` is low at a rising edge of `clk`, every stored bit becomes 0 on that edge.
- R2: Mode `2'b00` (hold) with `clr_n` high leaves the stored word unchanged across the edge.
- R3: Mode `2'b01` (shift up) with `clr_n` high moves stored bit i-1 into bit i for i = 1..W-1, and loads `ser_up_in` into bit 0.
- R4: Mode `2'b10` (shift down) with `clr_n` high moves stored bit i+1 into bit i for i = 0..W-2, and loads `ser_down_in` into bit W-1.
- R5: Mode `2'b11` (capture) with `clr_n` high stores the value of `bus_in` on the edge.
- R6: `bus_oe` is 1 exactly when `en_a_n` and `en_b_n` are both 0 and the mode is not `2'b11`. This is purely combinational, with no clock delay.
- R7: `bus_out` always carries the stored word (bit 0 is the low end). `tap_low` equals stored bit 0 and `tap_high` equals stored bit W-1, independent of `en_a_n` and `en_b_n`.
- R8: Clear wins over capture. With `clr_n` low and mode `2'b11`, the register becomes 0 whatever `bus_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous active-low clear |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 capture |
| ser_up_in | input | 1 | Serial bit entering bit 0 while shifting up |
| ser_down_in | input | 1 | Serial bit entering bit W-1 while shifting down |
| en_a_n | input | 1 | Active-low port enable, first of two |
| en_b_n | input | 1 | Active-low port enable, second of two |
| bus_in | input | W | Word sampled from the shared pins |
| bus_out | output | W | Stored word offered to the shared pins |
| bus_oe | output | 1 | Drive enable for the shared pins |
| tap_low | output | 1 | Always-on copy of stored bit 0 |
| tap_high | output | 1 | Always-on copy of stored bit W-1 |

## Verification
Shifts are tried with constant-one and constant-zero serial streams. This separates the serial entry point from the neighbour-to-neighbour path and shows which direction a bit travels. Captures use alternating and complementary words, so that a swapped or stuck bit cannot hide. A clear is applied together with a capture of an all-ones word to show that clear has priority. A long run of pseudo-random modes, enables and data is compared every cycle against a behavioural model. This exposes wrong mode decoding and a drive enable that ignores one of its three conditions.

// File: rtl/usr_pkg.sv
// Package: shared mode encoding for the bidirectional shift register.
// Assumes: a 2-bit select; encodings are fixed because software-visible.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_KEEP    = 2'b00,
        MODE_UP      = 2'b01,
        MODE_DOWN    = 2'b10,
        MODE_CAPTURE = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_next_word.sv
// Module: per-bit next-state selection for hold, both shifts and capture.
// Assumes: clear is applied downstream in the state register; purely combinational.
module usr_next_word
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  usr_mode_e      mode,
    input  logic [W-1:0]   cur,
    input  logic           ser_up,
    input  logic           ser_down,
    input  logic [W-1:0]   cap,
    output logic [W-1:0]   nxt
);
    localparam int TOP = W - 1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_low_end
            assign from_below = ser_up;
        end else begin : g_low_mid
            assign from_below = cur[i-1];
        end

        if (i == TOP) begin : g_high_end
            assign from_above = ser_down;
        end else begin : g_high_mid
            assign from_above = cur[i+1];
        end

        // Choose this bit's source according to the mode.
        always_comb begin
            unique case (mode)
                MODE_KEEP:    nxt[i] = cur[i];
                MODE_UP:      nxt[i] = from_below;
                MODE_DOWN:    nxt[i] = from_above;
                MODE_CAPTURE: nxt[i] = cap[i];
                default:      nxt[i] = cur[i];
            endcase
        end
    end
endmodule

// File: rtl/usr_store.sv
// Module: the W storage flops with synchronous active-low clear.
// Assumes: clear has priority over any next value offered.
module usr_store #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           clr_n,
    input  logic [W-1:0]   nxt,
    output logic [W-1:0]   q
);
    // Update the stored word on each rising edge; clear first.
    always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/usr_drive_ctl.sv
// Module: drive-enable decode for the shared parallel port.
// Assumes: both enables active low; capture mode always releases the pins.
module usr_drive_ctl
    import usr_pkg::*;
(
    input  usr_mode_e mode,
    input  logic      en_a_n,
    input  logic      en_b_n,
    output logic      oe
);
    // Drive only when both enables are asserted and no capture is pending.
    always_comb begin
        oe = ~en_a_n & ~en_b_n & (mode != MODE_CAPTURE);
    end
endmodule

// File: rtl/bidir_shift_reg.sv
// Module: universal shift/storage register with a shared parallel port.
// Assumes: the port is split into in/out/oe and resolved outside this block;
//          all state changes on the rising clock edge.
module bidir_shift_reg
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [1:0]   mode_sel,
    input  logic         ser_up_in,
    input  logic         ser_down_in,
    input  logic         en_a_n,
    input  logic         en_b_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic         tap_low,
    output logic         tap_high
);
    localparam int TOP = W - 1;

    usr_mode_e    mode;
    logic [W-1:0] word_q;
    logic [W-1:0] word_d;

    assign mode = usr_mode_e'(mode_sel);

    usr_next_word #(.W(W)) next_i (
        .mode     (mode),
        .cur      (word_q),
        .ser_up   (ser_up_in),
        .ser_down (ser_down_in),
        .cap      (bus_in),
        .nxt      (word_d)
    );

    usr_store #(.W(W)) store_i (
        .clk   (clk),
        .clr_n (clr_n),
        .nxt   (word_d),
        .q     (word_q)
    );

    usr_drive_ctl drive_i (
        .mode   (mode),
        .en_a_n (en_a_n),
        .en_b_n (en_b_n),
        .oe     (bus_oe)
    );

    assign bus_out  = word_q;
    assign tap_low  = word_q[0];
    assign tap_high = word_q[TOP];
endmodule

// File: rtl/usr_checker.sv
// Module: property checker for bidir_shift_reg, bound to every instance.
// Assumes: sees only the top-level ports; arms after its first clock edge.
module usr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clr_n,
    input logic [1:0]   mode_sel,
    input logic         ser_up_in,
    input logic         ser_down_in,
    input logic         en_a_n,
    input logic         en_b_n,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] bus_out,
    input logic         bus_oe,
    input logic         tap_low,
    input logic         tap_high
);
    logic armed = 1'b0;

    // Mark that one edge has been seen so $past values are meaningful.
    always_ff @(posedge clk) armed <= 1'b1;

    // R1: clear empties the register
    a_r1_clear_zero: assert property (@(posedge clk)
        armed && !$past(clr_n) |-> bus_out == '0);
    // R2: hold keeps the word
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!clr_n)
        armed && $past(clr_n) && $past(mode_sel) == 2'b00 |-> $stable(bus_out));
    // R3: shift up
    a_r3_shift_up: assert property (@(posedge clk) disable iff (!clr_n)
        armed && $past(clr_n) && $past(mode_sel) == 2'b01
        |-> bus_out == {$past(bus_out[W-2:0]), $past(ser_up_in)});
    // R4: shift down
    a_r4_shift_down: assert property (@(posedge clk) disable iff (!clr_n)
        armed && $past(clr_n) && $past(mode_sel) == 2'b10
        |-> bus_out == {$past(ser_down_in), $past(bus_out[W-1:1])});
    // R5: capture takes the port word
    a_r5_capture: assert property (@(posedge clk) disable iff (!clr_n)
        armed && $past(clr_n) && $past(mode_sel) == 2'b11 |-> bus_out == $past(bus_in));
    // R6: capture mode releases the pins
    a_r6_release_on_capture: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b11 |-> !bus_oe);
    // R6: any deasserted enable releases the pins
    a_r6_release_on_enable: assert property (@(posedge clk) disable iff (!clr_n)
        (en_a_n || en_b_n) |-> !bus_oe);
    // R7: serial taps follow the end bits
    a_r7_taps: assert property (@(posedge clk) disable iff (!clr_n)
        tap_low == bus_out[0] && tap_high == bus_out[W-1]);
    // R8: clear beats capture
    a_r8_clear_over_capture: assert property (@(posedge clk)
        armed && !$past(clr_n) && $past(mode_sel) == 2'b11 |-> bus_out == '0);
endmodule

bind bidir_shift_reg usr_checker #(.W(W)) chk_i (.*);

// File: tb/bidir_shift_reg_tb_top.sv
// Bench: drives bidir_shift_reg and compares it with a behavioural model every cycle.
module bidir_shift_reg_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic         ser_up_in = 1'b0;
    logic         ser_down_in = 1'b0;
    logic         en_a_n = 1'b1;
    logic         en_b_n = 1'b1;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic         bus_oe;
    logic         tap_low;
    logic         tap_high;

    int compared = 0;
    int mismatched = 0;
    logic [W-1:0] model = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bidir_shift_reg #(.W(W)) dut_i (.*);

    // Compare one observed value with its expected value and log any failure.
    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of inputs, then check the enable, the word and the taps.
    task automatic step(input logic c, input logic [1:0] m, input logic up, input logic dn,
                        input logic ea, input logic eb, input logic [W-1:0] d);
        string tag;
        logic exp_oe;
        clr_n = c; mode_sel = m; ser_up_in = up; ser_down_in = dn;
        en_a_n = ea; en_b_n = eb; bus_in = d;
        #1;
        exp_oe = !ea && !eb && (m != 2'b11);
        check("R6 drive enable", {{(W-1){1'b0}}, bus_oe}, {{(W-1){1'b0}}, exp_oe});
        @(posedge clk);
        if (!c) model = '0;
        else begin
            case (m)
                2'b00: model = model;
                2'b01: model = {model[W-2:0], up};
                2'b10: model = {dn, model[W-1:1]};
                default: model = d;
            endcase
        end
        @(negedge clk);
        if (!c && m == 2'b11) tag = "R8 clear over capture";
        else if (!c)          tag = "R1 clear";
        else if (m == 2'b00)  tag = "R2 hold";
        else if (m == 2'b01)  tag = "R3 shift up";
        else if (m == 2'b10)  tag = "R4 shift down";
        else                  tag = "R5 capture";
        check(tag, bus_out, model);
        check("R7 taps", {{(W-2){1'b0}}, tap_high, tap_low},
              {{(W-2){1'b0}}, model[W-1], model[0]});
    endtask

    initial begin
        @(negedge clk);
        step(1'b0, 2'b00, 0, 0, 1, 1, '0);               // R1 reset state
        step(1'b1, 2'b11, 0, 0, 0, 0, 8'hA5);            // R5 capture, pins released
        step(1'b1, 2'b00, 1, 1, 0, 1, 8'hFF);            // R2 hold, one enable off
        for (int i = 0; i < 3; i++) step(1'b1, 2'b01, 1, 0, 0, 0, '0);   // R3 ones in
        for (int i = 0; i < 2; i++) step(1'b1, 2'b01, 0, 1, 1, 0, '0);   // R3 zeros in
        step(1'b1, 2'b11, 0, 0, 1, 1, 8'h5A);            // R5 complement word
        for (int i = 0; i < 3; i++) step(1'b1, 2'b10, 0, 1, 0, 0, '0);   // R4 ones in
        for (int i = 0; i < 2; i++) step(1'b1, 2'b10, 1, 0, 0, 0, '0);   // R4 zeros in
        step(1'b0, 2'b11, 1, 1, 0, 0, 8'hFF);            // R8 clear beats capture
        step(1'b1, 2'b11, 0, 0, 0, 0, 8'h81);            // R7 end bits set
        step(1'b1, 2'b00, 0, 0, 1, 1, 8'h00);            // R7 taps with enables off
        for (int i = 0; i < 400; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            step(r[3:0] != 4'd0, r[5:4], r[6], r[7], r[8], r[9], W'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reports the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule